// File: doc/BRIEF.md
# Four-Mode Serial Port with Address Filter

This block is a full-duplex serial port. Software writes a byte to the data port, and that write loads the transmit shifter and starts a frame. Received bytes are read from a separate receive buffer register. An 8-bit control register sets the operating mode and the receive enable, and it holds the transmitted and received ninth bits and the two completion flags. The completion flags are set by hardware and stay set until software writes them back to zero.

The port has four modes. Mode 0 is a synchronous shift register clocked at one twelfth of the core clock. It moves data on the bidirectional data pin and drives its shift clock on the transmit pin. Mode 1 is a 10-bit asynchronous frame. Modes 2 and 3 are 11-bit frames that carry a ninth bit. Mode 2 runs at a fixed fraction of the core clock. Modes 1 and 3 take their rate from an external overflow tick. A doubling input speeds up every asynchronous mode by a factor of two.

The receiver samples the line at sixteen times the bit rate. It rejects false start bits. In the 9-bit modes it can drop every frame whose ninth bit is zero, so that a node on a shared line wakes only for address frames.

Top module: `serial_port_top`

## Requirements
- R1: After reset, txd and rxd_out are 1, rxd_oe is 0, ctl_rdata is 0x00 and rx_data is 0x00.
- R2: The control bits are [7:6] mode (00 shift, 01 8-bit frame, 10 fixed-rate 9-bit frame, 11 tick-rate 9-bit frame), [5] filter enable, [4] receive enable, [3] transmit ninth bit, [2] received ninth bit, [1] transmit-done flag and [0] receive-done flag. Both flags stay at 1 until a control write clears them.
- R3: In mode 0, a data write shifts 8 bits out LSB first on rxd_out with rxd_oe high. txd carries a clock with a period of 12 core clocks, 6 low then 6 high, and rxd_out is stable at each rising edge of txd. The transmit-done flag is set after the eighth bit.
- R4: In mode 0 with receive enable at 1 and the receive-done flag at 0, reception starts by itself. rxd_in is sampled while txd is low, LSB first. After 8 bits the byte appears on rx_data and the receive-done flag is set.
- R5: Mode 1 sends a frame of a 0 start bit, 8 data bits LSB first and a 1 stop bit. One bit lasts 16 overflow ticks when smod is 1, and 32 when smod is 0.
- R6: Modes 2 and 3 send start, 8 data bits, control bit 3 as the ninth bit, and stop. In mode 2 one bit lasts 64 core clocks, or 32 when smod is 1. Mode 3 uses the same timing as mode 1.
- R7: The transmit-done flag is 0 during the last bit before the stop bit and is 1 during the stop bit.
- R8: A received frame loads rx_data, sets the receive-done flag and writes control bit 2. Bit 2 takes the ninth bit in modes 2 and 3, and the stop bit in mode 1.
- R9: With filter enable at 1 in modes 2 and 3, a frame whose ninth bit is 0 leaves the receive-done flag and rx_data unchanged. A frame whose ninth bit is 1 is accepted.
- R10: A frame that completes while the receive-done flag is already 1 is dropped: rx_data and control bit 2 do not change.
- R11: A low pulse on rxd_in that is high again at the middle of the start bit is not taken as a frame. The receiver then accepts the next valid frame.
- R12: With receive enable at 0, a frame on rxd_in in a framed mode changes neither the receive-done flag nor rx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register contents |
| dat_wr | input | 1 | Write strobe for the transmit data |
| dat_wdata | input | 8 | Byte to transmit |
| rx_data | output | 8 | Receive buffer |
| smod | input | 1 | Rate doubling select |
| ovf_tick | input | 1 | One-cycle overflow pulse that sets the mode 1 and mode 3 rate |
| rxd_in | input | 1 | Serial data input |
| rxd_out | output | 1 | Mode 0 serial data output |
| rxd_oe | output | 1 | Drive enable for rxd_out |
| txd | output | 1 | Serial output, or the shift clock in mode 0 |

## Verification
Transmission is tried in every mode. The bytes are chosen so that they differ in their low and high bits, and the ninth bit is tried at both values. A scoreboard decodes the line at mid-bit with the bit period the requirements give, so a wrong rate, a wrong bit order or a wrong ninth bit each gives wrong data. Reception is tried with clean frames, with a short low pulse, with the filter seeing a ninth bit of 0 and then 1, with the receive-done flag still set, and with receive enable at 0. Each of these results can be seen at rx_data and in the control flags.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    MD_SHIFT     = 2'b00,
    MD_UART8     = 2'b01,
    MD_UART9_FIX = 2'b10,
    MD_UART9_VAR = 2'b11
  } sp_mode_e;

  // Majority of three samples taken around mid-bit.
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Number of source events between two oversampling ticks.
  // Fixed-rate mode counts core clocks. The other framed modes count overflow ticks.
  function automatic logic [2:0] tick_div(input sp_mode_e m, input logic dbl);
    if (m == MD_UART9_FIX) return dbl ? 3'd2 : 3'd4;
    return dbl ? 3'd1 : 3'd2;
  endfunction

  // Index of the stop bit in a frame: start = 0, then data, then an optional ninth bit.
  function automatic int unsigned stop_index(input int unsigned dw, input logic nine);
    return nine ? dw + 2 : dw + 1;
  endfunction

endpackage

// File: rtl/sp_baud.sv
module sp_baud
  import sp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sp_mode_e mode,
  input  logic     dbl,
  input  logic     ovf_tick,
  output logic     s16
);
  logic [2:0] cnt;
  logic [2:0] div;
  logic       src;
  logic       at_wrap;

  always_comb begin
    div     = tick_div(mode, dbl);
    src     = (mode == MD_UART9_FIX) ? 1'b1 : ovf_tick;
    at_wrap = (cnt >= div - 3'd1);
    s16     = (mode != MD_SHIFT) && src && at_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (mode == MD_SHIFT) cnt <= '0;
    else if (src)              cnt <= at_wrap ? 3'd0 : cnt + 3'd1;
  end

  // The fixed-rate mode never gives two oversampling ticks in a row.
  assert_s16_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_UART9_FIX && s16) |=> (mode != MD_UART9_FIX || !s16));

endmodule

// File: rtl/sp_shift0.sv
module sp_shift0 #(
  parameter int DATA_W = 8,
  parameter int DIV    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tx_go,
  input  logic              rx_arm,
  input  logic [DATA_W-1:0] data,
  input  logic              rxd_in,
  output logic              sclk,
  output logic              dout,
  output logic              oe,
  output logic              ti_set,
  output logic              rx_load,
  output logic [DATA_W-1:0] rx_data
);
  localparam int HALF = DIV / 2;
  localparam int C_W  = $clog2(DIV);
  localparam int I_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic              active, is_tx;
  logic [C_W-1:0]    cnt;
  logic [I_W-1:0]    idx;
  logic [DATA_W-1:0] sh;
  logic              start_tx, start_rx, bit_end, done;

  always_comb begin
    start_tx = en && tx_go && !active;
    start_rx = en && rx_arm && !active && !start_tx;
    bit_end  = active && (cnt == C_W'(DIV - 1));
    done     = bit_end && (idx == I_W'(DATA_W - 1));
    ti_set   = done && is_tx;
    rx_load  = done && !is_tx;
    oe       = active && is_tx;
    sclk     = active ? (cnt >= C_W'(HALF)) : 1'b1;
    dout     = oe ? sh[0] : 1'b1;
    rx_data  = sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; is_tx <= 1'b0; cnt <= '0; idx <= '0; sh <= '0;
    end else if (!en) begin
      active <= 1'b0;
    end else if (start_tx) begin
      active <= 1'b1; is_tx <= 1'b1; sh <= data; cnt <= '0; idx <= '0;
    end else if (start_rx) begin
      active <= 1'b1; is_tx <= 1'b0; sh <= '0; cnt <= '0; idx <= '0;
    end else if (active) begin
      // Receive samples in the low half of the shift clock.
      if (!is_tx && cnt == C_W'(HALF - 1)) sh <= {rxd_in, sh[DATA_W-1:1]};
      if (bit_end) begin
        cnt <= '0;
        if (idx == I_W'(DATA_W - 1)) active <= 1'b0;
        else begin
          idx <= idx + 1'b1;
          if (is_tx) sh <= {1'b1, sh[DATA_W-1:1]};
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // The shift clock always begins a transmit with its low half.
  assert_m0_clk_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !sclk);

endmodule

// File: rtl/sp_uart_tx.sv
module sp_uart_tx
  import sp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              nine,
  input  logic              s16,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  output logic              txd,
  output logic              busy,
  output logic              ti_set
);
  localparam int FRM_W = DATA_W + 3;
  localparam int IDX_W = $clog2(FRM_W);
  localparam int OS_W  = $clog2(OVS);

  logic [FRM_W-1:0] frame;
  logic [IDX_W-1:0] idx, last;
  logic [OS_W-1:0]  os;
  logic             bit_end;

  always_comb begin
    last    = IDX_W'(stop_index(DATA_W, nine));
    bit_end = busy && s16 && (os == OS_W'(OVS - 1));
    ti_set  = bit_end && (idx == last - 1'b1);
    txd     = busy ? frame[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; frame <= '1; idx <= '0; os <= '0;
    end else if (!en) begin
      busy <= 1'b0;
    end else if (load) begin
      busy  <= 1'b1;
      frame <= {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
      idx   <= '0;
      os    <= '0;
    end else if (busy && s16) begin
      if (os == OS_W'(OVS - 1)) begin
        os <= '0;
        if (idx == last) busy <= 1'b0;
        else begin
          idx   <= idx + 1'b1;
          frame <= {1'b1, frame[FRM_W-1:1]};
        end
      end else begin
        os <= os + 1'b1;
      end
    end
  end

  // The done flag is raised at the edge where the line enters the stop bit.
  assert_stop_after_ti_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ti_set |=> txd);

endmodule

// File: rtl/sp_uart_rx.sv
module sp_uart_rx
  import sp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              nine,
  input  logic              ren,
  input  logic              filt_en,
  input  logic              hold,
  input  logic              s16,
  input  logic              rxd,
  output logic              accept,
  output logic [DATA_W-1:0] data_o,
  output logic              rb8_o
);
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam int OS_W  = $clog2(OVS);
  localparam int MID   = OVS / 2;

  logic              rx_meta, rx_s;
  logic              busy;
  logic [OS_W-1:0]   os;
  logic [IDX_W-1:0]  idx, last;
  logic [1:0]        smp;
  logic [DATA_W-1:0] data_r;
  logic              b9_r;
  logic              bit_val, vote_pt, frame_end, filt_bit;

  always_comb begin
    last      = IDX_W'(stop_index(DATA_W, nine));
    bit_val   = vote3(smp[1], smp[0], rx_s);
    vote_pt   = busy && s16 && (os == OS_W'(MID + 1));
    frame_end = vote_pt && (idx == last);
    filt_bit  = nine ? b9_r : bit_val;
    accept    = frame_end && !hold && (!filt_en || filt_bit);
    data_o    = data_r;
    rb8_o     = filt_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1; rx_s <= 1'b1;
    end else begin
      rx_meta <= rxd; rx_s <= rx_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; os <= '0; idx <= '0; smp <= '1; data_r <= '0; b9_r <= 1'b0;
    end else if (!en) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (ren && s16 && !rx_s) begin
        busy <= 1'b1; os <= OS_W'(1); idx <= '0;
      end
    end else if (s16) begin
      os <= (os == OS_W'(OVS - 1)) ? '0 : os + 1'b1;
      if (os == OS_W'(MID - 1) || os == OS_W'(MID)) smp <= {smp[0], rx_s};
      if (os == OS_W'(OVS - 1)) idx <= idx + 1'b1;
      if (vote_pt) begin
        if (idx == '0) begin
          if (bit_val) busy <= 1'b0;
        end else if (idx <= IDX_W'(DATA_W)) begin
          data_r <= {bit_val, data_r[DATA_W-1:1]};
        end else if (nine && idx == IDX_W'(DATA_W + 1)) begin
          b9_r <= bit_val;
        end
        if (idx == last) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_port_top.sv
module serial_port_top
  import sp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int M0_DIV = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic [DATA_W-1:0] rx_data,
  input  logic              smod,
  input  logic              ovf_tick,
  input  logic              rxd_in,
  output logic              rxd_out,
  output logic              rxd_oe,
  output logic              txd
);
  localparam int B_RI  = 0;
  localparam int B_TI  = 1;
  localparam int B_RB8 = 2;
  localparam int B_TB8 = 3;
  localparam int B_REN = 4;
  localparam int B_SM2 = 5;

  logic [7:0]        ctl_q, ctl_d;
  logic [DATA_W-1:0] rx_buf;
  sp_mode_e          mode;
  logic              framed, nine, s16;
  logic              u_busy, u_txd, u_ti, u_acc, u_rb8;
  logic [DATA_W-1:0] u_data;
  logic              m_sclk, m_dout, m_oe, m_ti, m_rxld;
  logic [DATA_W-1:0] m_data;
  logic              ti_evt, ri_evt;

  always_comb begin
    mode   = sp_mode_e'(ctl_q[7:6]);
    framed = (mode != MD_SHIFT);
    nine   = (mode == MD_UART9_FIX) || (mode == MD_UART9_VAR);
  end

  sp_baud u_baud (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dbl(smod), .ovf_tick(ovf_tick), .s16(s16)
  );

  sp_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(framed), .nine(nine), .s16(s16),
    .load(dat_wr && framed && !u_busy), .data(dat_wdata), .bit9(ctl_q[B_TB8]),
    .txd(u_txd), .busy(u_busy), .ti_set(u_ti)
  );

  sp_uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(framed), .nine(nine), .ren(ctl_q[B_REN]),
    .filt_en(ctl_q[B_SM2]), .hold(ctl_q[B_RI]), .s16(s16), .rxd(rxd_in),
    .accept(u_acc), .data_o(u_data), .rb8_o(u_rb8)
  );

  sp_shift0 #(.DATA_W(DATA_W), .DIV(M0_DIV)) u_m0 (
    .clk(clk), .rst_n(rst_n), .en(!framed), .tx_go(dat_wr),
    .rx_arm(ctl_q[B_REN] && !ctl_q[B_RI]), .data(dat_wdata), .rxd_in(rxd_in),
    .sclk(m_sclk), .dout(m_dout), .oe(m_oe), .ti_set(m_ti), .rx_load(m_rxld),
    .rx_data(m_data)
  );

  always_comb begin
    ti_evt = u_ti || m_ti;
    ri_evt = u_acc || m_rxld;
    ctl_d  = ctl_wr ? ctl_wdata : ctl_q;
    if (ti_evt) ctl_d[B_TI]  = 1'b1;
    if (ri_evt) ctl_d[B_RI]  = 1'b1;
    if (u_acc)  ctl_d[B_RB8] = u_rb8;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      rx_buf <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (u_acc)       rx_buf <= u_data;
      else if (m_rxld) rx_buf <= m_data;
    end
  end

  assign ctl_rdata = ctl_q;
  assign rx_data   = rx_buf;
  assign txd       = framed ? u_txd : m_sclk;
  assign rxd_out   = m_dout;
  assign rxd_oe    = m_oe;

  // Flags clear only through a control write.
  assert_ti_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[B_TI] && !ctl_wr) |=> ctl_q[B_TI]);
  assert_ri_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[B_RI] && !ctl_wr) |=> ctl_q[B_RI]);
  // The buffer changes only at the edge where the receive flag rises.
  assert_rxbuf_needs_ri_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_buf != $past(rx_buf)) |-> (ctl_q[B_RI] && !$past(ctl_q[B_RI])));

endmodule

// File: tb/tb_serial_port_top.sv
`timescale 1ns/1ps
module tb_serial_port_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0, dat_wr = 1'b0;
  logic [7:0] ctl_wdata = '0, dat_wdata = '0;
  logic [7:0] ctl_rdata, rx_data;
  logic       smod = 1'b0, ovf_tick = 1'b0, rxd_in = 1'b1;
  logic       rxd_out, rxd_oe, txd;

  int errors = 0, checks = 0;
  int ovfp = 1;
  int cur_bp = 16;
  bit mon_on = 0, mon_nine = 0;
  logic [8:0] exp_q[$];

  always #4 clk = ~clk;

  serial_port_top dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .rx_data(rx_data), .smod(smod),
    .ovf_tick(ovf_tick), .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd(txd)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bit length in core clocks, restated from R5 and R6.
  function automatic int bit_clocks(input logic [1:0] m, input logic dbl, input int per);
    if (m == 2'b10) return dbl ? 32 : 64;
    return (dbl ? 16 : 32) * per;
  endfunction

  // Overflow tick source: one pulse every ovfp clocks.
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      if (c >= ovfp) begin ovf_tick = 1'b1; c = 0; end
      else ovf_tick = 1'b0;
    end
  end

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic dat_write(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  // mode, filter, receive enable, tx ninth bit; both flags written 0
  task automatic cfg(input logic [1:0] m, input logic f, input logic r, input logic t9);
    ctl_write({m, f, r, t9, 3'b000});
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard driver for framed transmit
  task automatic send_tx(input logic [7:0] d, input logic b9, input int nbits);
    exp_q.push_back({b9, d});
    dat_write(d);
    wait_clks((nbits + 2) * cur_bp);
    chk(exp_q.size() == 0, "R5/R6 frame consumed", exp_q.size(), 0);
  endtask

  // Drive one framed byte on rxd_in.
  task automatic rx_frame(input logic [7:0] d, input logic b9, input bit nine, input int bp);
    @(negedge clk); rxd_in = 1'b0; wait_clks(bp - 1);
    for (int i = 0; i < 8; i++) begin rxd_in = d[i]; wait_clks(bp); end
    if (nine) begin rxd_in = b9; wait_clks(bp); end
    rxd_in = 1'b1; wait_clks(bp + 4);
  endtask

  // Monitor: decodes framed output at mid-bit and compares with the queue.
  initial begin
    forever begin
      @(negedge txd);
      if (mon_on) begin
        automatic int bp = cur_bp;
        automatic logic [8:0] got = '0;
        automatic logic [8:0] exp;
        wait_clks(bp / 2);
        chk(txd == 1'b0, "R5 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          wait_clks(bp);
          got[i] = txd;
        end
        if (mon_nine) begin
          wait_clks(bp);
          got[8] = txd;
        end
        chk(ctl_rdata[1] == 1'b0, "R7 TI low before stop", ctl_rdata[1], 0);
        wait_clks(bp);
        chk(txd == 1'b1, "R5 stop bit", txd, 1);
        chk(ctl_rdata[1] == 1'b1, "R7 TI high in stop", ctl_rdata[1], 1);
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected frame", got, 0);
        else begin
          exp = exp_q.pop_front();
          if (!mon_nine) exp[8] = 1'b0;
          chk(got == exp, "R6 frame content", got, exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] m0d;
    logic [7:0] got8;
    realtime    t_prev;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);
    // R1 reset state
    chk(txd == 1'b1 && rxd_out == 1'b1, "R1 idle pins", {txd, rxd_out}, 2'b11);
    chk(rxd_oe == 1'b0, "R1 oe", rxd_oe, 0);
    chk(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 0);
    chk(rx_data == 8'h00, "R1 rx_data", rx_data, 0);

    // R3 mode 0 transmit
    cfg(2'b00, 0, 0, 0);
    m0d = 8'hA5; got8 = '0; t_prev = 0;
    dat_write(m0d);
    for (int k = 0; k < 8; k++) begin
      @(posedge txd);
      if (k > 0) chk(($realtime - t_prev) == 96.0, "R3 shift clock period", int'($realtime - t_prev), 96);
      t_prev = $realtime;
      #1;
      got8[k] = rxd_out;
      if (k == 0) chk(rxd_oe == 1'b1, "R3 oe during shift", rxd_oe, 1);
    end
    chk(got8 == m0d, "R3 shifted byte", got8, m0d);
    wait_clks(10);
    chk(ctl_rdata[1] == 1'b1, "R3 TI after shift", ctl_rdata[1], 1);
    chk(rxd_oe == 1'b0, "R3 oe released", rxd_oe, 0);

    // R4 mode 0 receive
    m0d = 8'h3C;
    cfg(2'b00, 0, 1, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge txd); #1; rxd_in = m0d[k];
    end
    wait_clks(16);
    rxd_in = 1'b1;
    chk(ctl_rdata[0] == 1'b1, "R4 RI", ctl_rdata[0], 1);
    chk(rx_data == m0d, "R4 rx byte", rx_data, m0d);

    // R5 mode 1 transmit, tick every clock, doubled
    smod = 1'b1; ovfp = 1;
    cfg(2'b01, 0, 0, 0);
    cur_bp = bit_clocks(2'b01, smod, ovfp); mon_nine = 0; mon_on = 1;
    send_tx(8'h5A, 1'b0, 10);
    cfg(2'b01, 0, 0, 0);
    send_tx(8'h81, 1'b0, 10);

    // R8 mode 1 receive, RB8 gets the stop bit
    cfg(2'b01, 0, 1, 0);
    rx_frame(8'hC3, 1'b0, 0, cur_bp);
    chk(ctl_rdata[0] == 1'b1, "R8 RI mode1", ctl_rdata[0], 1);
    chk(rx_data == 8'hC3, "R8 data mode1", rx_data, 8'hC3);
    chk(ctl_rdata[2] == 1'b1, "R8 RB8 stop", ctl_rdata[2], 1);

    // R6 mode 2 transmit at both rates
    smod = 1'b0;
    cfg(2'b10, 0, 0, 1);
    cur_bp = bit_clocks(2'b10, smod, ovfp); mon_nine = 1;
    send_tx(8'h96, 1'b1, 11);
    smod = 1'b1;
    cfg(2'b10, 0, 0, 0);
    cur_bp = bit_clocks(2'b10, smod, ovfp);
    send_tx(8'h0F, 1'b0, 11);

    // R8 mode 2 receive, ninth bit 0
    cfg(2'b10, 0, 1, 0);
    rx_frame(8'h6D, 1'b0, 1, cur_bp);
    chk(ctl_rdata[0] == 1'b1, "R8 RI mode2", ctl_rdata[0], 1);
    chk(rx_data == 8'h6D, "R8 data mode2", rx_data, 8'h6D);
    chk(ctl_rdata[2] == 1'b0, "R8 RB8 ninth", ctl_rdata[2], 0);

    // R11 glitch rejection, then a valid frame
    cfg(2'b10, 0, 1, 0);
    @(negedge clk); rxd_in = 1'b0; wait_clks(3); rxd_in = 1'b1;
    wait_clks(3 * cur_bp);
    chk(ctl_rdata[0] == 1'b0, "R11 no RI on glitch", ctl_rdata[0], 0);
    chk(rx_data == 8'h6D, "R11 buffer kept", rx_data, 8'h6D);
    rx_frame(8'h24, 1'b1, 1, cur_bp);
    chk(rx_data == 8'h24 && ctl_rdata[0], "R11 next frame taken", rx_data, 8'h24);

    // R10 RI still set: frame dropped
    rx_frame(8'h99, 1'b0, 1, cur_bp);
    chk(rx_data == 8'h24, "R10 buffer kept", rx_data, 8'h24);
    chk(ctl_rdata[2] == 1'b1, "R10 RB8 kept", ctl_rdata[2], 1);

    // R9 mode 3 filter, tick every third clock
    smod = 1'b0; ovfp = 3;
    cfg(2'b11, 1, 1, 1);
    cur_bp = bit_clocks(2'b11, smod, ovfp);
    rx_frame(8'h11, 1'b0, 1, cur_bp);
    chk(ctl_rdata[0] == 1'b0, "R9 data frame filtered", ctl_rdata[0], 0);
    chk(rx_data == 8'h24, "R9 buffer kept", rx_data, 8'h24);
    rx_frame(8'hEE, 1'b1, 1, cur_bp);
    chk(ctl_rdata[0] == 1'b1, "R9 address frame RI", ctl_rdata[0], 1);
    chk(rx_data == 8'hEE, "R9 address byte", rx_data, 8'hEE);

    // R6 mode 3 transmit with ninth bit 1
    cfg(2'b11, 0, 0, 1);
    send_tx(8'h3C, 1'b1, 11);

    // R12 receive disabled
    smod = 1'b1; ovfp = 1;
    cfg(2'b01, 0, 0, 0);
    cur_bp = bit_clocks(2'b01, smod, ovfp);
    rx_frame(8'h55, 1'b0, 0, cur_bp);
    chk(ctl_rdata[0] == 1'b0, "R12 no RI", ctl_rdata[0], 0);
    chk(rx_data == 8'hEE, "R12 buffer kept", rx_data, 8'hEE);

    // R2 flags cleared by a control write
    chk(ctl_rdata[7:6] == 2'b01, "R2 mode field", ctl_rdata[7:6], 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule